// File: doc/BRIEF.md
# Dual-Mode Pixel Output Formatter

This block sits behind a video link receiver and turns its decoded pixel stream into a 36-bit panel bus. Each clock it takes one pixel of three 8-bit colour channels, together with data enable, horizontal and vertical sync and three general control bits. A runtime mode input selects the packing. Single-pixel mode puts one 24-bit pixel on the low bits of the bus every clock. Dual-pixel mode cuts each pixel to 6 bits per channel and packs an even and an odd pixel into one word, so the panel-side clock runs at half the pixel rate.

The block also produces the panel clock controls. These are a run enable that can stop the clock during blanking, a polarity flag that picks the capture edge, and, in dual-pixel mode, the level of the half-rate clock itself. Two active-low power-down inputs force the outputs into a disabled state and drive output-enable flags that stand in for tri-state drivers. The output power-down spares control bit 1 and the lock flag. The full power-down disables everything.

Top module: `pix_out_fmt`

## Requirements
- R1: While `rst_n` is low, every output, including both enable flags, is 0.
- R2: With `sel_dual` = 0, the pixel at the inputs appears one clock later on `out_data` as red in bits 23:16, green in 15:8 and blue in 7:0, with bits 35:24 at 0.
- R3: With `sel_dual` = 1, each pixel is reduced to the 6 most significant bits of each channel, packed as {red, green, blue} into 18 bits. The even pixel sits in bits 17:0 and the odd pixel in bits 35:18. The word appears on `out_data` one clock after the odd pixel and is held until the next pair completes.
- R4: In dual-pixel mode, the first pixel with `vid_de` = 1 after a clock with `vid_de` = 0 is an even pixel. Otherwise, even and odd pixels alternate every clock, and the first pixel after reset is even.
- R5: If `vid_de` is 0 on the odd slot of a pair whose even pixel had `vid_de` = 1, bits 35:18 of that word are 0.
- R6: `out_de`, `out_hs`, `out_vs` and `out_ctl` stay aligned with the data. In single-pixel mode they are the inputs of one clock earlier. In dual-pixel mode they carry the values of the pair's even pixel and change together with `out_data`.
- R7: `ock_run` is 1 unless the stop select, registered one clock, is 1 while `out_de` is 0.
- R8: `ock_pol` is the polarity select registered one clock. In dual-pixel mode, when `ock_pol` = 0, `ock_half` is 1 exactly in the clock after each pair word is loaded; `ock_pol` = 1 inverts this. `ock_half` is 0 whenever `ock_run` is 0 and whenever the registered mode is single-pixel.
- R9: One clock after `pdo_n` is low, `out_data`, `out_de`, `out_hs`, `out_vs`, `out_ctl[2:1]`, `ock_run`, `ock_half`, `ock_pol` and `oe_main` are 0. `out_ctl[0]`, `out_lock` and `oe_aux` keep working normally.
- R10: One clock after `pd_n` is low, every output is 0, including `out_ctl[0]`, `out_lock` and `oe_aux`.
- R11: `out_lock` follows `lock_in` with one clock of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_r | input | 8 | Red channel of the incoming pixel |
| pix_g | input | 8 | Green channel of the incoming pixel |
| pix_b | input | 8 | Blue channel of the incoming pixel |
| vid_de | input | 1 | Data enable of the incoming pixel |
| vid_hs | input | 1 | Horizontal sync |
| vid_vs | input | 1 | Vertical sync |
| vid_ctl | input | 3 | Control bits; bit 0 is control 1 |
| sel_dual | input | 1 | 1 = two pixels per word, 0 = one pixel per word |
| sel_inv | input | 1 | Output clock polarity select |
| sel_stop | input | 1 | 1 = stop the output clock while DE is low |
| pdo_n | input | 1 | Active-low output power-down |
| pd_n | input | 1 | Active-low full power-down |
| lock_in | input | 1 | Sync-detect flag from the receiver |
| out_data | output | 36 | Panel data bus |
| out_de | output | 1 | Aligned data enable |
| out_hs | output | 1 | Aligned horizontal sync |
| out_vs | output | 1 | Aligned vertical sync |
| out_ctl | output | 3 | Aligned control bits |
| out_lock | output | 1 | Registered sync-detect flag |
| ock_run | output | 1 | Output clock run enable |
| ock_half | output | 1 | Half-rate output clock level in dual-pixel mode |
| ock_pol | output | 1 | Output clock inversion flag |
| oe_main | output | 1 | Enable for data, syncs, DE, control bits 2 and 3, and clock |
| oe_aux | output | 1 | Enable for control bit 1 and the lock flag |

## Verification
The bench uses the default parameters: 8-bit input channels, 6-bit packed channels and a 36-bit bus. With these values the two dropped low bits of each channel can be seen, and the dual-pixel word fills the bus exactly. The bench runs lines of even and odd active length in both modes, with both polarities and with clock stop on and off. This covers both the zero-filled odd half and a DE rise that restarts the pairing in mid-pair. Output power-down and full power-down are applied in the middle of a line, which shows which outputs each one spares.

// File: rtl/pof_pkg.sv
package pof_pkg;
   localparam int NUM_CH  = 3;
   localparam int NUM_CTL = 3;

   typedef struct packed {
      logic               de;
      logic               hs;
      logic               vs;
      logic [NUM_CTL-1:0] ctl;
   } vid_ctrl_t;

   typedef enum logic {
      SLOT_EVEN = 1'b0,
      SLOT_ODD  = 1'b1
   } slot_e;
endpackage

// File: rtl/pof_phase.sv
module pof_phase
   import pof_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic de,
   output logic odd_now
);
   slot_e nxt_slot;
   logic  de_d;
   logic  de_rise;

   assign de_rise = de && !de_d;
   assign odd_now = (nxt_slot == SLOT_ODD) && !de_rise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nxt_slot <= SLOT_EVEN;
         de_d     <= 1'b0;
      end else begin
         nxt_slot <= odd_now ? SLOT_EVEN : SLOT_ODD;
         de_d     <= de;
      end
   end
endmodule

// File: rtl/pof_packer.sv
module pof_packer
   import pof_pkg::*;
#(
   parameter int CH_W      = 8,
   parameter int NAR_W     = 6,
   parameter bit ZERO_FILL = 1'b1,
   localparam int PIX_W    = NUM_CH * CH_W,
   localparam int HALF_W   = NUM_CH * NAR_W,
   localparam int BUS_W    = 2 * HALF_W
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIX_W-1:0] pix,
   input  vid_ctrl_t        ctl_in,
   input  logic             dual,
   input  logic             odd_now,
   output logic [BUS_W-1:0] data_q,
   output vid_ctrl_t        ctl_q,
   output logic             pair_q
);
   localparam int PAD_W = BUS_W - PIX_W;

   logic [HALF_W-1:0] nar;
   logic [HALF_W-1:0] ev_nar;
   vid_ctrl_t         ev_ctl;
   logic [HALF_W-1:0] odd_half;
   logic [BUS_W-1:0]  single_word;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_trim
      assign nar[c*NAR_W +: NAR_W] = pix[c*CH_W + CH_W - NAR_W +: NAR_W];
   end

   if (PAD_W > 0) begin : g_pad
      assign single_word = {{PAD_W{1'b0}}, pix};
   end else begin : g_nopad
      assign single_word = pix[BUS_W-1:0];
   end

   if (ZERO_FILL) begin : g_zfill
      assign odd_half = (!ctl_in.de && ev_ctl.de) ? '0 : nar;
   end else begin : g_keep
      assign odd_half = nar;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ev_nar <= '0;
         ev_ctl <= '0;
      end else if (!odd_now) begin
         ev_nar <= nar;
         ev_ctl <= ctl_in;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         ctl_q  <= '0;
         pair_q <= 1'b0;
      end else begin
         pair_q <= dual && odd_now;
         if (!dual) begin
            data_q <= single_word;
            ctl_q  <= ctl_in;
         end else if (odd_now) begin
            data_q <= {odd_half, ev_nar};
            ctl_q  <= ev_ctl;
         end
      end
   end
endmodule

// File: rtl/pof_clkgen.sv
module pof_clkgen (
   input  logic clk,
   input  logic rst_n,
   input  logic stop_en,
   input  logic pol,
   input  logic dual,
   input  logic de_q,
   input  logic pair_q,
   output logic run_raw,
   output logic half_raw,
   output logic pol_raw
);
   logic stop_r;
   logic pol_r;
   logic mode_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stop_r <= 1'b0;
         pol_r  <= 1'b0;
         mode_r <= 1'b0;
      end else begin
         stop_r <= stop_en;
         pol_r  <= pol;
         mode_r <= dual;
      end
   end

   assign run_raw  = !(stop_r && !de_q);
   assign half_raw = mode_r && run_raw && (pair_q ^ pol_r);
   assign pol_raw  = pol_r;
endmodule

// File: rtl/pof_gate.sv
module pof_gate
   import pof_pkg::*;
#(
   parameter int BUS_W = 36
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pd_n,
   input  logic               pdo_n,
   input  logic               lock_in,
   input  logic [BUS_W-1:0]   data_raw,
   input  vid_ctrl_t          ctl_raw,
   input  logic               run_raw,
   input  logic               half_raw,
   input  logic               pol_raw,
   output logic [BUS_W-1:0]   data_o,
   output logic               de_o,
   output logic               hs_o,
   output logic               vs_o,
   output logic [NUM_CTL-1:0] ctl_o,
   output logic               lock_o,
   output logic               run_o,
   output logic               half_o,
   output logic               pol_o,
   output logic               en_main,
   output logic               en_aux
);
   logic lock_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_main <= 1'b0;
         en_aux  <= 1'b0;
         lock_q  <= 1'b0;
      end else begin
         en_main <= pd_n && pdo_n;
         en_aux  <= pd_n;
         lock_q  <= lock_in;
      end
   end

   assign data_o = en_main ? data_raw : '0;
   assign de_o   = en_main && ctl_raw.de;
   assign hs_o   = en_main && ctl_raw.hs;
   assign vs_o   = en_main && ctl_raw.vs;
   assign run_o  = en_main && run_raw;
   assign half_o = en_main && half_raw;
   assign pol_o  = en_main && pol_raw;
   assign lock_o = en_aux && lock_q;

   for (genvar k = 0; k < NUM_CTL; k++) begin : g_ctl
      if (k == 0) begin : g_aux
         assign ctl_o[k] = en_aux && ctl_raw.ctl[k];
      end else begin : g_main
         assign ctl_o[k] = en_main && ctl_raw.ctl[k];
      end
   end
endmodule

// File: rtl/pix_out_fmt.sv
module pix_out_fmt
   import pof_pkg::*;
#(
   parameter int CH_W      = 8,
   parameter int NAR_W     = 6,
   parameter bit ZERO_FILL = 1'b1,
   localparam int BUS_W    = 2 * NUM_CH * NAR_W
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CH_W-1:0]    pix_r,
   input  logic [CH_W-1:0]    pix_g,
   input  logic [CH_W-1:0]    pix_b,
   input  logic               vid_de,
   input  logic               vid_hs,
   input  logic               vid_vs,
   input  logic [NUM_CTL-1:0] vid_ctl,
   input  logic               sel_dual,
   input  logic               sel_inv,
   input  logic               sel_stop,
   input  logic               pdo_n,
   input  logic               pd_n,
   input  logic               lock_in,
   output logic [BUS_W-1:0]   out_data,
   output logic               out_de,
   output logic               out_hs,
   output logic               out_vs,
   output logic [NUM_CTL-1:0] out_ctl,
   output logic               out_lock,
   output logic               ock_run,
   output logic               ock_half,
   output logic               ock_pol,
   output logic               oe_main,
   output logic               oe_aux
);
   if (NAR_W < 1 || NAR_W > CH_W) begin : g_bad_nar
      $error("pix_out_fmt: NAR_W must lie between 1 and CH_W");
   end
   if (NUM_CH * CH_W > BUS_W) begin : g_bad_bus
      $error("pix_out_fmt: a full-width pixel does not fit the packed bus");
   end

   logic [NUM_CH*CH_W-1:0] pix;
   vid_ctrl_t              ctl_in;
   vid_ctrl_t              ctl_q;
   logic [BUS_W-1:0]       data_q;
   logic                   odd_now;
   logic                   pair_q;
   logic                   run_raw;
   logic                   half_raw;
   logic                   pol_raw;

   assign pix        = {pix_r, pix_g, pix_b};
   assign ctl_in.de  = vid_de;
   assign ctl_in.hs  = vid_hs;
   assign ctl_in.vs  = vid_vs;
   assign ctl_in.ctl = vid_ctl;

   pof_phase u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .de      (vid_de),
      .odd_now (odd_now)
   );

   pof_packer #(.CH_W(CH_W), .NAR_W(NAR_W), .ZERO_FILL(ZERO_FILL)) u_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .pix     (pix),
      .ctl_in  (ctl_in),
      .dual    (sel_dual),
      .odd_now (odd_now),
      .data_q  (data_q),
      .ctl_q   (ctl_q),
      .pair_q  (pair_q)
   );

   pof_clkgen u_clk (
      .clk      (clk),
      .rst_n    (rst_n),
      .stop_en  (sel_stop),
      .pol      (sel_inv),
      .dual     (sel_dual),
      .de_q     (ctl_q.de),
      .pair_q   (pair_q),
      .run_raw  (run_raw),
      .half_raw (half_raw),
      .pol_raw  (pol_raw)
   );

   pof_gate #(.BUS_W(BUS_W)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .pd_n     (pd_n),
      .pdo_n    (pdo_n),
      .lock_in  (lock_in),
      .data_raw (data_q),
      .ctl_raw  (ctl_q),
      .run_raw  (run_raw),
      .half_raw (half_raw),
      .pol_raw  (pol_raw),
      .data_o   (out_data),
      .de_o     (out_de),
      .hs_o     (out_hs),
      .vs_o     (out_vs),
      .ctl_o    (out_ctl),
      .lock_o   (out_lock),
      .run_o    (ock_run),
      .half_o   (ock_half),
      .pol_o    (ock_pol),
      .en_main  (oe_main),
      .en_aux   (oe_aux)
   );
endmodule

// File: rtl/pof_chk.sv
module pof_chk #(
   parameter int CH_W   = 8,
   parameter int NAR_W  = 6,
   localparam int BUS_W = 6 * NAR_W,
   localparam int PIX_W = 3 * CH_W
)(
   input logic             clk,
   input logic             rst_n,
   input logic             sel_dual,
   input logic             sel_stop,
   input logic             pd_n,
   input logic             pdo_n,
   input logic [2:0]       vid_ctl,
   input logic [BUS_W-1:0] out_data,
   input logic             out_de,
   input logic [2:0]       out_ctl,
   input logic             out_lock,
   input logic             ock_run,
   input logic             ock_half,
   input logic             ock_pol,
   input logic             oe_main,
   input logic             oe_aux
);
   logic armed;

   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assert_pad_low_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (!$past(sel_dual) && oe_main) |-> (out_data[BUS_W-1:PIX_W] == '0));

   assert_quiet_main_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      !$past(pdo_n) |-> (out_data == '0 && !out_de && !oe_main && !ock_run && !ock_half
                         && !ock_pol && out_ctl[2:1] == 2'b00));

   assert_ctl1_kept_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ($past(pd_n) && !$past(sel_dual)) |-> (out_ctl[0] == $past(vid_ctl[0]) && oe_aux));

   assert_full_off_R10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      !$past(pd_n) |-> (!out_lock && !oe_aux && !out_ctl[0] && out_data == '0));

   assert_run_free_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ($past(pd_n) && $past(pdo_n) && !$past(sel_stop)) |-> ock_run);

   assert_half_on_load_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (oe_main && $past(oe_main) && $past(sel_dual) && ock_run && !ock_pol
       && out_data != $past(out_data)) |-> ock_half);
endmodule

bind pix_out_fmt pof_chk #(.CH_W(CH_W), .NAR_W(NAR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sel_dual (sel_dual),
   .sel_stop (sel_stop),
   .pd_n     (pd_n),
   .pdo_n    (pdo_n),
   .vid_ctl  (vid_ctl),
   .out_data (out_data),
   .out_de   (out_de),
   .out_ctl  (out_ctl),
   .out_lock (out_lock),
   .ock_run  (ock_run),
   .ock_half (ock_half),
   .ock_pol  (ock_pol),
   .oe_main  (oe_main),
   .oe_aux   (oe_aux)
);

// File: tb/pix_out_fmt_test.sv
`timescale 1ns/1ps
module pix_out_fmt_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  pix_r = '0, pix_g = '0, pix_b = '0;
   logic        vid_de = 1'b0, vid_hs = 1'b0, vid_vs = 1'b0;
   logic [2:0]  vid_ctl = '0;
   logic        sel_dual = 1'b0, sel_inv = 1'b0, sel_stop = 1'b0;
   logic        pdo_n = 1'b1, pd_n = 1'b1, lock_in = 1'b0;
   logic [35:0] out_data;
   logic        out_de, out_hs, out_vs, out_lock;
   logic [2:0]  out_ctl;
   logic        ock_run, ock_half, ock_pol, oe_main, oe_aux;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 0;
   string ph  = "R1 reset";

   always #4 clk = ~clk;

   pix_out_fmt uut (
      .clk(clk), .rst_n(rst_n), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
      .vid_de(vid_de), .vid_hs(vid_hs), .vid_vs(vid_vs), .vid_ctl(vid_ctl),
      .sel_dual(sel_dual), .sel_inv(sel_inv), .sel_stop(sel_stop),
      .pdo_n(pdo_n), .pd_n(pd_n), .lock_in(lock_in),
      .out_data(out_data), .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs),
      .out_ctl(out_ctl), .out_lock(out_lock), .ock_run(ock_run),
      .ock_half(ock_half), .ock_pol(ock_pol), .oe_main(oe_main), .oe_aux(oe_aux)
   );

   // reference model state
   typedef struct {
      logic [17:0] n;
      logic de, hs, vs;
      logic [2:0] ctl;
   } held_t;
   held_t       pend[$];
   logic [35:0] m_data;
   logic        m_de, m_hs, m_vs, m_lock, m_fresh, m_stop, m_pol, m_mode;
   logic [2:0]  m_ctl;
   logic        m_en_main, m_en_aux, m_next_odd, m_de_d;

   function automatic logic [17:0] trim6(logic [7:0] r, logic [7:0] g, logic [7:0] b);
      return {r[7:2], g[7:2], b[7:2]};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         pend.delete();
         m_data = '0; m_de = 0; m_hs = 0; m_vs = 0; m_ctl = '0; m_lock = 0;
         m_fresh = 0; m_stop = 0; m_pol = 0; m_mode = 0;
         m_en_main = 0; m_en_aux = 0; m_next_odd = 0; m_de_d = 0;
      end else begin
         automatic bit rise = vid_de && !m_de_d;
         automatic bit is_odd = m_next_odd && !rise;
         automatic held_t cur;
         cur.n = trim6(pix_r, pix_g, pix_b);
         cur.de = vid_de; cur.hs = vid_hs; cur.vs = vid_vs; cur.ctl = vid_ctl;
         if (!sel_dual) begin
            m_data = {12'h000, pix_r, pix_g, pix_b};
            m_de = vid_de; m_hs = vid_hs; m_vs = vid_vs; m_ctl = vid_ctl;
         end else if (is_odd) begin
            automatic held_t ev = pend[0];
            m_data = {(!vid_de && ev.de) ? 18'h0 : cur.n, ev.n};
            m_de = ev.de; m_hs = ev.hs; m_vs = ev.vs; m_ctl = ev.ctl;
         end
         m_fresh = sel_dual && is_odd;
         if (!is_odd) begin
            pend.delete();
            pend.push_back(cur);
         end
         m_next_odd = !is_odd;
         m_de_d = vid_de;
         m_stop = sel_stop; m_pol = sel_inv; m_mode = sel_dual;
         m_en_main = pd_n && pdo_n; m_en_aux = pd_n; m_lock = lock_in;
      end
   end

   task automatic chk(bit ok, string tag, logic [63:0] got, logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s [%s] at cycle %0d: actual %h expected %h", tag, ph, cyc, got, exp);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (!rst_n) begin
         chk({out_data, out_de, out_hs, out_vs, out_ctl, out_lock, ock_run, ock_half,
              ock_pol, oe_main, oe_aux} == '0, "R1", {28'h0, out_data}, 64'h0);
      end else if (cyc > 1) begin
         automatic logic [35:0] e_data = m_en_main ? m_data : '0;
         automatic logic [5:0]  e_ctl  = {m_en_main && m_de, m_en_main && m_hs, m_en_main && m_vs,
                                          m_en_main && m_ctl[2], m_en_main && m_ctl[1],
                                          m_en_aux && m_ctl[0]};
         automatic logic e_run  = m_en_main && !(m_stop && !m_de);
         automatic logic e_half = e_run && m_mode && (m_fresh ^ m_pol);
         automatic logic [2:0] e_clk = {e_run, e_half, m_en_main && m_pol};
         chk(out_data == e_data, m_mode ? "R3" : "R2", {28'h0, out_data}, {28'h0, e_data});
         chk({out_de, out_hs, out_vs, out_ctl} == e_ctl, "R6",
             {58'h0, out_de, out_hs, out_vs, out_ctl}, {58'h0, e_ctl});
         chk({ock_run, ock_half, ock_pol} == e_clk, m_mode ? "R8" : "R7",
             {61'h0, ock_run, ock_half, ock_pol}, {61'h0, e_clk});
         chk({oe_main, oe_aux} == {m_en_main, m_en_aux}, "R9/R10",
             {62'h0, oe_main, oe_aux}, {62'h0, m_en_main, m_en_aux});
         chk(out_lock == (m_en_aux && m_lock), "R11", {63'h0, out_lock}, {63'h0, m_en_aux && m_lock});
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         fails++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic drive(logic [7:0] r, logic [7:0] g, logic [7:0] b, logic de, logic hs);
      @(posedge clk); #2;
      pix_r = r; pix_g = g; pix_b = b; vid_de = de; vid_hs = hs;
      vid_ctl = 3'($urandom); vid_vs = ($urandom % 16) == 0;
      if (($urandom % 8) == 0) lock_in = ~lock_in;
   endtask

   task automatic line(int act, int blank);
      for (int i = 0; i < act; i++) drive(8'($urandom), 8'($urandom), 8'($urandom), 1'b1, 1'b0);
      for (int i = 0; i < blank; i++) drive(8'($urandom), 8'($urandom), 8'($urandom), 1'b0, i > 1 && i < 4);
   endtask

   initial begin
      logic [7:0] a0, a1, a2;
      repeat (4) @(posedge clk);
      #2 rst_n = 1'b1;

      ph = "R2 single";
      for (int k = 0; k < 4; k++) line(20, 6);
      sel_inv = 1'b1;
      line(9, 5);

      ph = "R7 single stop";
      sel_stop = 1'b1;
      for (int k = 0; k < 3; k++) line(12, 7);

      ph = "R3 dual even line";
      sel_dual = 1'b1; sel_inv = 1'b0;
      line(0, 4);
      for (int k = 0; k < 3; k++) line(10, 6);
      ph = "R5 dual odd line";
      for (int k = 0; k < 3; k++) line(7, 5);
      ph = "R8 dual inverted free-running";
      sel_inv = 1'b1; sel_stop = 1'b0;
      for (int k = 0; k < 3; k++) line(11, 4);
      ph = "R4 restart after one blank";
      sel_inv = 1'b0;
      for (int k = 0; k < 4; k++) line(5, 1);
      line(6, 2);

      // directed pairing and zero-fill check
      ph = "R4 R5 directed";
      line(0, 3);
      a0 = 8'hA7; a1 = 8'h5C; a2 = 8'hF1;
      drive(a0, ~a0, a0 ^ 8'h3C, 1'b1, 1'b0);
      drive(a1, ~a1, a1 ^ 8'h3C, 1'b1, 1'b0);
      drive(a2, ~a2, a2 ^ 8'h3C, 1'b1, 1'b0);
      @(negedge clk);
      chk(out_data == {trim6(a1, ~a1, a1 ^ 8'h3C), trim6(a0, ~a0, a0 ^ 8'h3C)}, "R4",
          {28'h0, out_data}, {28'h0, trim6(a1, ~a1, a1 ^ 8'h3C), trim6(a0, ~a0, a0 ^ 8'h3C)});
      drive(8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0);
      drive(8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0);
      @(negedge clk);
      chk(out_data == {18'h0, trim6(a2, ~a2, a2 ^ 8'h3C)} && out_de, "R5",
          {27'h0, out_de, out_data}, {28'h1, 18'h0, trim6(a2, ~a2, a2 ^ 8'h3C)});

      ph = "R9 output power-down";
      for (int i = 0; i < 6; i++) drive(8'($urandom), 8'($urandom), 8'($urandom), 1'b1, 1'b0);
      pdo_n = 1'b0;
      line(6, 3);
      pdo_n = 1'b1;
      sel_dual = 1'b0;
      line(4, 0);
      pdo_n = 1'b0;
      line(5, 3);
      pdo_n = 1'b1;
      ph = "R10 full power-down";
      line(3, 0);
      pd_n = 1'b0;
      line(6, 4);
      pd_n = 1'b1;
      sel_dual = 1'b1;
      line(8, 4);
      ph = "R11 tail";
      line(10, 6);

      @(posedge clk); @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule